// File: doc/BRIEF.md
# Safe-Phase Event Synchronizer

This block moves an asynchronous start or stop event into the timing domain of a multi-phase reference clock without letting any capturing flip-flop see a marginal setup time. A delay line spreads the reference period across sixteen equally spaced phases. When the event arrives, a bank of latches freezes the state of those phases, and the block copies that snapshot. The block then waits a fixed number of phase steps so the latches can settle. It searches the settled snapshot for the point where a phase turns from low to high. It then arms only the flip-flop of a phase a fixed distance past that point, because that edge is known to be far enough from the event. The OR of the flip-flop outputs forms the synchronized strobe, which a fine interpolator uses to sample the raw event.

In this model the phase edges are single-cycle enables, driven on a one-hot vector and sampled by a fast simulation clock. The snapshot arrives as a parallel vector together with an event pulse. A re-arm input clears the block between events. If the snapshot holds no low-to-high point, the block flags an error and does not fire a strobe.

Top module: `safe_phase_sync`

## Requirements
- R1: While reset is high and on the first cycle after it, sel_o, sel_vld_o, err_o and strobe_o are all 0.
- R2: An event pulse seen while the block is idle captures lat_i. Bit i of the snapshot is a rising point when bit i is 1 and bit (i-1) mod 16 is 0, so bit 0 is compared with bit 15.
- R3: If the snapshot holds more than one rising point, the lowest-numbered one is used.
- R4: The selected phase is the rising index plus 6, modulo 16. It appears on sel_o with sel_vld_o = 1.
- R5: The snapshot is judged only after 6 phase ticks, counted as cycles with any phase_tick_i bit set, following the event cycle. sel_vld_o rises one cycle after the sixth tick, so it is 7 cycles after the event when a tick arrives every cycle.
- R6: strobe_o rises one cycle after the clock edge that samples the tick of the selected phase, and ticks of other phases never set it.
- R7: At most one phase flip-flop is armed per event, and at most one is ever set.
- R8: A snapshot with no rising point (all zeros or all ones) sets err_o, leaves sel_vld_o at 0, and no strobe follows.
- R9: Event pulses that arrive while an event is in progress are ignored and leave the result unchanged.
- R10: A re-arm pulse returns all outputs to 0 on the next cycle and makes the block ready for a new event.
- R11: Once raised, strobe_o stays high until re-arm or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast simulation clock |
| rst | input | 1 | Synchronous active-high reset |
| rearm_i | input | 1 | Clears the block before the next event |
| evt_i | input | 1 | Event arrival pulse |
| lat_i | input | 16 | Latched phase states at event arrival |
| phase_tick_i | input | 16 | One-hot tick, bit k marks an edge of phase k |
| sel_o | output | 4 | Selected synchronizing phase |
| sel_vld_o | output | 1 | sel_o is valid |
| err_o | output | 1 | No rising point found in the snapshot |
| strobe_o | output | 1 | Synchronized event strobe |

## Verification
The embedded properties hold on every cycle. At most one phase is armed or set. The strobe never appears without a valid selection, and never together with an error. A new flip-flop bit is set only by a tick of an armed phase. The snapshot does not move while the block is busy, and re-arm clears the outputs. Only the bench scenarios can show which phase is chosen for a given snapshot, including the modulo wrap and the lowest-index priority. They also show the exact settling latency, the fact that gapped ticks stretch the wait, and the edge on which the strobe rises relative to the selected tick.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_DECIDE = 3'd2,
    ST_ARMED  = 3'd3,
    ST_DONE   = 3'd4
  } sps_state_t;
endpackage

// File: rtl/sps_edge_find.sv
module sps_edge_find #(
  parameter int NPH  = 16,
  parameter int IDXW = $clog2(NPH)
) (
  input  logic [NPH-1:0]  snap_i,
  output logic            found_o,
  output logic [IDXW-1:0] idx_o
);
  logic [NPH-1:0] rise;

  // a rising point: this phase high, the one before it (circularly) low
  for (genvar g = 0; g < NPH; g++) begin : g_rise
    assign rise[g] = snap_i[g] & ~snap_i[(g + NPH - 1) % NPH];
  end

  always_comb begin
    idx_o = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (rise[i]) idx_o = IDXW'(i);
    end
  end

  assign found_o = |rise;
endmodule

// File: rtl/sps_phase_ring.sv
module sps_phase_ring #(
  parameter int NPH  = 16,
  parameter int IDXW = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            arm_en_i,
  input  logic [IDXW-1:0] arm_idx_i,
  input  logic [NPH-1:0]  tick_i,
  output logic            hit_o
);
  logic [NPH-1:0] armed_q;
  logic [NPH-1:0] ff_q;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        armed_q[g] <= 1'b0;
        ff_q[g]    <= 1'b0;
      end else begin
        if (arm_en_i && arm_idx_i == IDXW'(g)) armed_q[g] <= 1'b1;
        if (armed_q[g] && tick_i[g])           ff_q[g]    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) hit_o <= 1'b0;
    else              hit_o <= |ff_q;
  end

  // R7
  armed_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(armed_q));
  // R7
  ff_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ff_q));
  // R6
  ff_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ((ff_q & ~$past(ff_q)) & ~$past(armed_q & tick_i)) == '0);
endmodule

// File: rtl/safe_phase_sync.sv
module safe_phase_sync
  import sps_pkg::*;
#(
  parameter int NPH    = 16,
  parameter int SETTLE = 6,
  parameter int OFFSET = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rearm_i,
  input  logic                   evt_i,
  input  logic [NPH-1:0]         lat_i,
  input  logic [NPH-1:0]         phase_tick_i,
  output logic [$clog2(NPH)-1:0] sel_o,
  output logic                   sel_vld_o,
  output logic                   err_o,
  output logic                   strobe_o
);
  localparam int IDXW = $clog2(NPH);
  localparam int CNTW = $clog2(SETTLE + 1);

  sps_state_t      st_q;
  logic [CNTW-1:0] cnt_q;
  logic [NPH-1:0]  lat_r;
  logic            found;
  logic [IDXW-1:0] idx;
  logic [IDXW:0]   sum;
  logic [IDXW-1:0] nxt_sel;
  logic            arm_en;
  logic            hit;

  sps_edge_find #(.NPH(NPH), .IDXW(IDXW)) u_find (
    .snap_i (lat_r),
    .found_o(found),
    .idx_o  (idx)
  );

  always_comb begin
    sum = {1'b0, idx} + (IDXW + 1)'(OFFSET);
    if (sum >= (IDXW + 1)'(NPH)) sum = sum - (IDXW + 1)'(NPH);
    nxt_sel = sum[IDXW-1:0];
  end

  assign arm_en = (st_q == ST_DECIDE) && found;

  sps_phase_ring #(.NPH(NPH), .IDXW(IDXW)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (rearm_i),
    .arm_en_i (arm_en),
    .arm_idx_i(nxt_sel),
    .tick_i   (phase_tick_i),
    .hit_o    (hit)
  );

  always_ff @(posedge clk) begin
    if (rst || rearm_i) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      lat_r     <= '0;
      sel_o     <= '0;
      sel_vld_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (evt_i) begin
          lat_r <= lat_i;
          cnt_q <= '0;
          st_q  <= ST_WAIT;
        end
        ST_WAIT: if (|phase_tick_i) begin
          if (cnt_q == CNTW'(SETTLE - 1)) st_q <= ST_DECIDE;
          else                            cnt_q <= cnt_q + 1'b1;
        end
        ST_DECIDE: if (found) begin
          sel_o     <= nxt_sel;
          sel_vld_o <= 1'b1;
          st_q      <= ST_ARMED;
        end else begin
          err_o <= 1'b1;
          st_q  <= ST_DONE;
        end
        ST_ARMED: if (hit) st_q <= ST_DONE;
        default: st_q <= st_q;
      endcase
    end
  end

  assign strobe_o = hit;

  // R6
  strobe_has_sel_chk: assert property (@(posedge clk) disable iff (rst) strobe_o |-> sel_vld_o);
  // R8
  err_no_strobe_chk: assert property (@(posedge clk) disable iff (rst) err_o |-> !strobe_o);
  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && !rearm_i) |=> $stable(lat_r));
  // R10
  rearm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rearm_i |=> (!strobe_o && !sel_vld_o && !err_o));
  // R2
  edge_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DECIDE && found) |->
      (lat_r[idx] && !lat_r[(int'(idx) + NPH - 1) % NPH]));
  // R5
  wait_no_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> !sel_vld_o);
endmodule

// File: tb/safe_phase_sync_tb.sv
module safe_phase_sync_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rearm = 1'b0;
  logic        evt = 1'b0;
  logic [15:0] lat = '0;
  logic [15:0] tick = '0;
  logic [3:0]  sel;
  logic        vld, err, strobe;

  int          errors = 0;
  int          checks = 0;
  int          cur_ph = 0;
  bit          gap_mode = 1'b0;
  bit          gap_tog = 1'b0;
  logic [15:0] hist1 = '0;
  logic [15:0] hist2 = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  safe_phase_sync dut_i (
    .clk(clk), .rst(rst), .rearm_i(rearm), .evt_i(evt), .lat_i(lat),
    .phase_tick_i(tick), .sel_o(sel), .sel_vld_o(vld), .err_o(err), .strobe_o(strobe)
  );

  // {snapshot, expected error, expected phase}
  localparam logic [20:0] VEC [8] = '{
    {16'h00FE, 1'b0, 4'd7},   // rise at 1
    {16'hF000, 1'b0, 4'd2},   // rise at 12, wraps
    {16'h00FF, 1'b0, 4'd6},   // rise at 0 (bit 15 low)
    {16'hFF00, 1'b0, 4'd14},  // rise at 8
    {16'h8000, 1'b0, 4'd5},   // rise at 15, wraps
    {16'h0F0C, 1'b0, 4'd8},   // rises at 2 and 8, lowest wins
    {16'h0000, 1'b1, 4'd0},   // no rise
    {16'hFFFF, 1'b1, 4'd0}    // no rise
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    hist2 = hist1;
    hist1 = tick;
    if (gap_mode) gap_tog = ~gap_tog;
    if (!gap_mode || gap_tog) begin
      tick = 16'(1) << cur_ph;
      cur_ph = (cur_ph + 1) % 16;
    end else begin
      tick = '0;
    end
  endtask

  task automatic do_rearm();
    step(); rearm = 1'b1;
    step(); rearm = 1'b0;
    check(!vld && !err && !strobe, "R10", {vld, err, strobe}, 0);
  endtask

  task automatic fire(input logic [15:0] snap);
    step(); evt = 1'b1; lat = snap;
    step(); evt = 1'b0; lat = '0;
  endtask

  task automatic run_case(input logic [15:0] snap, input bit e_err, input logic [3:0] e_sel);
    bit seen;
    fire(snap);
    for (int k = 0; k < 6; k++) step();
    check(!vld && !err, "R5", {vld, err}, 0);
    step();
    if (e_err) begin
      check(err && !vld, "R8", {vld, err}, 1);
      seen = 1'b0;
      for (int k = 0; k < 20; k++) begin step(); if (strobe) seen = 1'b1; end
      check(!seen, "R8", seen, 0);
    end else begin
      check(vld && !err && sel == e_sel, "R4", sel, e_sel);
      seen = 1'b0;
      for (int k = 0; k < 40 && !seen; k++) begin step(); seen = strobe; end
      check(seen && hist2 == (16'(1) << e_sel), "R6", hist2, 16'(1) << e_sel);
      for (int k = 0; k < 3; k++) step();
      check(strobe, "R11", strobe, 1);
    end
    do_rearm();
  endtask

  initial begin
    repeat (3) step();
    check(sel == 0 && !vld && !err && !strobe, "R1", {sel, vld, err, strobe}, 0);
    step(); rst = 1'b0;
    step();
    check(sel == 0 && !vld && !err && !strobe, "R1", {sel, vld, err, strobe}, 0);

    // table walk: R2 rise detection, R3 priority, R4 wrap, R8 error
    for (int v = 0; v < 8; v++) run_case(VEC[v][20:5], VEC[v][4], VEC[v][3:0]);

    // R9: a second event during settling is ignored
    fire(16'h00FE);
    step(); evt = 1'b1; lat = 16'hF000;
    step(); evt = 1'b0; lat = '0;
    for (int k = 0; k < 6; k++) step();
    check(vld && sel == 4'd7, "R9", sel, 7);
    do_rearm();

    // R5: gapped ticks stretch the settle wait
    gap_mode = 1'b1;
    fire(16'hFF00);
    for (int k = 0; k < 8; k++) step();
    check(!vld, "R5", vld, 0);
    for (int k = 0; k < 20 && !vld; k++) step();
    check(vld && sel == 4'd14, "R5", sel, 14);
    gap_mode = 1'b0;
    do_rearm();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule